// File: doc/BRIEF.md
# Powered-Device Mode Sequencer

This block is the digital control core of the input stage of a powered device that draws its supply from an Ethernet cable. Comparators outside the block turn the cable voltage, the return-node voltage, junction temperature and a wall-adapter sense into level flags. The sequencer passes these flags through two-flop synchronizers and decides the operating mode from them. Its registered outputs drive the signature pulldown, the classification current source, the isolation switch, the current-limit selector, the power-good sink that holds the downstream converter off, and the sink that reports a two-event (type-2) power source.

The sequencer records the classification probing before power is applied, so it can tell a type-2 source from a single-event one. It holds power-good low for a fixed minimum inrush time and until the switch is fully enhanced. It filters short undervoltage dips out of the power-off decision. It gives a wall adapter priority over the cable supply, and it restarts through inrush after an over-temperature shutdown. All timing comes from counters on one system clock whose frequency is a parameter.

Top module: `pd_mode_seq`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after, `sw_en`, `pg_sink`, `ev2_sink`, `cls_en` and `sig_pd_en` are 0, `ilim_sel` is 2'b00, and the type-2 latch is cleared.
- R2: When the block is unpowered, `sig_pd_en` is 1 exactly while the detection-band flag or the below-mark flag is set. `cls_en` is 1 exactly while the classification-band flag is set, the block is unpowered and no adapter is active. Neither output is ever 1 while the switch is enabled.
- R3: When the above-on flag sets, the block enters inrush: `sw_en`=1 and `pg_sink`=1. `ilim_sel` is 2'b01 (foldback) while the return-high flag is set and 2'b00 (inrush limit) otherwise.
- R4: Inrush lasts at least HOLD_CYC cycles (HOLD_US at CLK_KHZ) and until the switch-full flag is set. Power mode then gives `pg_sink`=0 and `ilim_sel`=2'b10 (normal).
- R5: Once powered, the block returns to the unpowered mode only after the below-off flag has been set for DEG_CYC+1 consecutive synchronized cycles. Shorter dips leave the mode unchanged.
- R6: A classification event, then a mark event (below-mark flag), then a second classification event and a second mark event, all while unpowered, set the type-2 latch. `ev2_sink` is 1 in power mode when the latch is set. A single event leaves it 0.
- R7: Only the below-reset flag (or `rst`) clears the type-2 latch. An undervoltage exit turns `ev2_sink` off, and the next power-up turns it on again if the latch has not been cleared.
- R8: A wall adapter is active when its flag is set and the below-mark flag is clear. While it is active, `sw_en`=0, `cls_en`=0 and `ev2_sink`=1. The indicator is not latched and drops when the adapter goes away.
- R9: Over-temperature forces `sw_en`=0, `ev2_sink`=0 and `pg_sink`=1. On recovery the block re-enters inrush with a full hold time.
- R10: A flag change reaches the outputs three clock edges after it is applied: two synchronizer stages and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| f_det_band | input | 1 | Input voltage in detection band |
| f_cls_band | input | 1 | Input voltage in classification band |
| f_below_mark | input | 1 | Input below mark threshold |
| f_below_reset | input | 1 | Input below type-2 reset threshold |
| f_above_on | input | 1 | Input above turn-on level |
| f_below_off | input | 1 | Input below turn-off level |
| f_wall | input | 1 | Wall adapter voltage present |
| f_over_temp | input | 1 | Junction over-temperature |
| f_sw_full | input | 1 | Isolation switch fully enhanced |
| f_rtn_high | input | 1 | Return voltage above foldback point |
| sig_pd_en | output | 1 | Signature pulldown enable |
| cls_en | output | 1 | Classification current enable |
| sw_en | output | 1 | Isolation switch enable |
| ilim_sel | output | 2 | Current limit: 00 inrush, 01 foldback, 10 normal |
| pg_sink | output | 1 | Power-good sink active (converter held off) |
| ev2_sink | output | 1 | Two-event / adapter indicator sink active |

## Verification
Two functions can collide in one cycle. The first pair is the undervoltage filter, which fires on the cycle after exactly DEG_CYC+1 low samples, and the type-2 indicator, which must follow the mode change in that same cycle. The second pair is the hold-off timer and a switch-full flag that is already set when inrush starts. The bench drives randomly sized dips around the DEG_CYC boundary, including exactly DEG_CYC and DEG_CYC+1, while the latch is set. A bench function predicts for each dip whether power-good reasserts on recovery. Power-good and the indicator are sampled just before and well after the hold count expires.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  localparam int F_DET  = 0;
  localparam int F_CLS  = 1;
  localparam int F_MARK = 2;
  localparam int F_RLOW = 3;
  localparam int F_ON   = 4;
  localparam int F_OFF  = 5;
  localparam int F_WALL = 6;
  localparam int F_HOT  = 7;
  localparam int F_FULL = 8;
  localparam int F_RTN  = 9;
  localparam int NFLAG  = 10;

  typedef enum logic [1:0] {
    ILIM_INR  = 2'b00,
    ILIM_FOLD = 2'b01,
    ILIM_NORM = 2'b10
  } ilim_e;

  typedef enum logic [1:0] {
    PS_IDLE, PS_INRUSH, PS_POWER, PS_HOT
  } pstate_e;

  typedef enum logic [2:0] {
    T_IDLE, T_C1, T_M1, T_C2, T_DONE
  } tstate_e;
endpackage

// File: rtl/pd_flag_sync.sv
module pd_flag_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/pd_uv_filter.sv
module pd_uv_filter #(
  parameter int unsigned LIMIT = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic low,
  output logic trip
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm || !low) cnt <= '0;
    else if (cnt != W'(LIMIT)) cnt <= cnt + 1'b1;
  end

  assign trip = arm && low && (cnt == W'(LIMIT));

  // R5
  uv_history_chk: assert property (@(posedge clk) disable iff (rst)
    trip |-> $past(low));
endmodule

// File: rtl/pd_dwell.sv
module pd_dwell #(
  parameter int unsigned CYC = 96
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int W = $clog2(CYC + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= W'(CYC);
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R4
  hold_start_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !done);
endmodule

// File: rtl/pd_t2_track.sv
module pd_t2_track
  import pd_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic cls,
  input  logic mark,
  input  logic rlow,
  output logic latched
);
  tstate_e ts_q, ts_d;

  always_comb begin
    ts_d = ts_q;
    if (rlow) ts_d = T_IDLE;
    else if (enable) begin
      case (ts_q)
        T_IDLE: if (cls)  ts_d = T_C1;
        T_C1:   if (mark) ts_d = T_M1;
        T_M1:   if (cls)  ts_d = T_C2;
        T_C2:   if (mark) ts_d = T_DONE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ts_q <= T_IDLE;
    else     ts_q <= ts_d;
  end

  assign latched = (ts_q == T_DONE);

  // R7
  t2_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rlow |=> !latched);
endmodule

// File: rtl/pd_mode_seq.sv
module pd_mode_seq
  import pd_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 100000,
  parameter int unsigned HOLD_US = 96000,
  parameter int unsigned DEG_US  = 60
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       f_det_band,
  input  logic       f_cls_band,
  input  logic       f_below_mark,
  input  logic       f_below_reset,
  input  logic       f_above_on,
  input  logic       f_below_off,
  input  logic       f_wall,
  input  logic       f_over_temp,
  input  logic       f_sw_full,
  input  logic       f_rtn_high,
  output logic       sig_pd_en,
  output logic       cls_en,
  output logic       sw_en,
  output logic [1:0] ilim_sel,
  output logic       pg_sink,
  output logic       ev2_sink
);
  localparam int unsigned HOLD_CYC = 32'((64'(CLK_KHZ) * 64'(HOLD_US)) / 64'd1000);
  localparam int unsigned DEG_CYC  = 32'((64'(CLK_KHZ) * 64'(DEG_US)) / 64'd1000);

  logic [NFLAG-1:0] raw, fs;
  assign raw[F_DET]  = f_det_band;
  assign raw[F_CLS]  = f_cls_band;
  assign raw[F_MARK] = f_below_mark;
  assign raw[F_RLOW] = f_below_reset;
  assign raw[F_ON]   = f_above_on;
  assign raw[F_OFF]  = f_below_off;
  assign raw[F_WALL] = f_wall;
  assign raw[F_HOT]  = f_over_temp;
  assign raw[F_FULL] = f_sw_full;
  assign raw[F_RTN]  = f_rtn_high;

  pd_flag_sync #(.N(NFLAG)) u_sync (.clk(clk), .rst(rst), .d(raw), .q(fs));

  pstate_e st_q, st_d;
  logic    hold_done, hold_load, uv_trip, t2, wall_act;

  assign wall_act = fs[F_WALL] && !fs[F_MARK];

  pd_uv_filter #(.LIMIT(DEG_CYC)) u_uv (
    .clk(clk), .rst(rst), .arm(st_q != PS_IDLE), .low(fs[F_OFF]), .trip(uv_trip));

  pd_dwell #(.CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst(rst), .load(hold_load), .run(st_q == PS_INRUSH), .done(hold_done));

  pd_t2_track u_t2 (
    .clk(clk), .rst(rst), .enable(st_q == PS_IDLE), .cls(fs[F_CLS]),
    .mark(fs[F_MARK]), .rlow(fs[F_RLOW]), .latched(t2));

  always_comb begin
    st_d = st_q;
    if (wall_act || uv_trip) st_d = PS_IDLE;
    else begin
      case (st_q)
        PS_IDLE:   if (fs[F_ON]) st_d = fs[F_HOT] ? PS_HOT : PS_INRUSH;
        PS_INRUSH: if (fs[F_HOT]) st_d = PS_HOT;
                   else if (hold_done && fs[F_FULL]) st_d = PS_POWER;
        PS_POWER:  if (fs[F_HOT]) st_d = PS_HOT;
        PS_HOT:    if (!fs[F_HOT]) st_d = PS_INRUSH;
        default:   st_d = PS_IDLE;
      endcase
    end
    hold_load = (st_d == PS_INRUSH) && (st_q != PS_INRUSH);
  end

  ilim_e ilim_q;
  logic  sig_q, cls_q, sw_q, pg_q, ev2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PS_IDLE;
      sig_q  <= 1'b0;
      cls_q  <= 1'b0;
      sw_q   <= 1'b0;
      pg_q   <= 1'b0;
      ev2_q  <= 1'b0;
      ilim_q <= ILIM_INR;
    end else begin
      st_q  <= st_d;
      sig_q <= (st_d == PS_IDLE) && (fs[F_DET] || fs[F_MARK]);
      cls_q <= (st_d == PS_IDLE) && fs[F_CLS] && !wall_act;
      sw_q  <= (st_d == PS_INRUSH) || (st_d == PS_POWER);
      pg_q  <= (st_d == PS_INRUSH) || (st_d == PS_HOT);
      ev2_q <= wall_act || (t2 && st_d == PS_POWER);
      if (st_d == PS_POWER)                      ilim_q <= ILIM_NORM;
      else if (st_d == PS_INRUSH && fs[F_RTN])   ilim_q <= ILIM_FOLD;
      else                                       ilim_q <= ILIM_INR;
    end
  end

  assign sig_pd_en = sig_q;
  assign cls_en    = cls_q;
  assign sw_en     = sw_q;
  assign pg_sink   = pg_q;
  assign ev2_sink  = ev2_q;
  assign ilim_sel  = ilim_q;

  // R2
  cls_sw_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(cls_en && sw_en) && !(sig_pd_en && sw_en));
  // R8
  wall_sw_chk: assert property (@(posedge clk) disable iff (rst)
    wall_act |=> (!sw_en && ev2_sink && !cls_en));
  // R9
  hot_sw_chk: assert property (@(posedge clk) disable iff (rst)
    fs[F_HOT] |=> !sw_en);
  // R4
  pg_release_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(pg_sink) && sw_en) |-> (ilim_sel == 2'b10));
endmodule

// File: tb/pd_mode_seq_bench.sv
module pd_mode_seq_bench;
  localparam int unsigned CLK_KHZ = 1000;
  localparam int unsigned HOLD_US = 96;
  localparam int unsigned DEG_US  = 30;
  localparam int HOLD = 96;
  localparam int DEG  = 30;

  logic clk = 1'b0, rst = 1'b1;
  logic det = 0, cls = 0, mark = 0, rlow = 0, on = 0, off = 0;
  logic wall = 0, hot = 0, full = 0, rtn = 0;
  logic sig, clsen, sw, pg, ev2;
  logic [1:0] ilim;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pd_mode_seq #(.CLK_KHZ(CLK_KHZ), .HOLD_US(HOLD_US), .DEG_US(DEG_US)) u_pd_mode_seq (
    .clk(clk), .rst(rst), .f_det_band(det), .f_cls_band(cls), .f_below_mark(mark),
    .f_below_reset(rlow), .f_above_on(on), .f_below_off(off), .f_wall(wall),
    .f_over_temp(hot), .f_sw_full(full), .f_rtn_high(rtn),
    .sig_pd_en(sig), .cls_en(clsen), .sw_en(sw), .ilim_sel(ilim),
    .pg_sink(pg), .ev2_sink(ev2));

  typedef enum {L_ZERO, L_DET, L_CLS, L_MID, L_ON} lvl_e;

  task automatic level(lvl_e l);
    det = (l == L_DET); cls = (l == L_CLS);
    mark = (l == L_ZERO) || (l == L_DET);
    rlow = (l == L_ZERO);
    on = (l == L_ON); off = (l != L_ON);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit dip_exits(int len);
    return len > DEG;
  endfunction

  task automatic power_up();
    level(L_ON); full = 1; step(HOLD + 12);
  endtask

  initial begin
    step(4);
    check("R1 sw", sw, 0); check("R1 pg", pg, 0); check("R1 ev2", ev2, 0);
    check("R1 cls", clsen, 0); check("R1 sig", sig, 0); check("R1 ilim", ilim, 0);
    rst = 0;
    level(L_MID); step(6);
    // R10 latency: three edges
    level(L_DET); step(2);
    check("R10 sig before", sig, 0);
    step(1);
    check("R10 sig after", sig, 1);
    step(3);
    check("R2 det sig", sig, 1); check("R2 det cls", clsen, 0);
    level(L_CLS); step(6);
    check("R2 cls sig", sig, 0); check("R2 cls en", clsen, 1);
    level(L_DET); step(6);
    level(L_MID); step(6);
    rtn = 1; full = 0; level(L_ON); step(6);
    check("R3 sw", sw, 1); check("R3 pg", pg, 1); check("R3 fold", ilim, 1);
    rtn = 0; cls = 1; step(6);
    check("R3 inrush", ilim, 0); check("R2 cls off powered", clsen, 0);
    cls = 0; step(HOLD + 10);
    check("R4 pg waits for full", pg, 1);
    full = 1; step(6);
    check("R4 pg off", pg, 0); check("R4 normal", ilim, 2);
    check("R6 single event", ev2, 0);
    level(L_ZERO); step(DEG + 10);
    check("R5 long exit sw", sw, 0);
    // R4 minimum hold with switch already full
    level(L_ON); step(HOLD - 2);
    check("R4 pg held", pg, 1);
    step(10);
    check("R4 pg after hold", pg, 0);
    // R6 type-2 sequence
    level(L_ZERO); step(DEG + 10);
    level(L_DET); step(6);
    level(L_CLS); step(6);
    level(L_DET); step(6);
    level(L_CLS); step(6);
    level(L_DET); step(6);
    level(L_MID); step(6);
    power_up();
    check("R6 ev2 on", ev2, 1);
    // R7 undervoltage exit then repower
    level(L_MID); step(DEG + 6);
    check("R7 ev2 off", ev2, 0); check("R5 sw off", sw, 0);
    power_up();
    check("R7 ev2 back", ev2, 1);
    // R5 directed boundary and random dips
    void'($urandom(32'h5eed));
    for (int i = 0; i < 14; i++) begin
      int len;
      len = (i == 0) ? DEG : (i == 1) ? DEG + 1 : DEG - 6 + int'($urandom_range(12, 0));
      level(L_MID); step(len);
      level(L_ON); step(6);
      check("R5 dip pg", pg, int'(dip_exits(len)));
      if (dip_exits(len)) step(HOLD + 10);
      check("R7 ev2 latched", ev2, 1);
    end
    // R9 over-temperature
    hot = 1; step(6);
    check("R9 sw", sw, 0); check("R9 ev2", ev2, 0); check("R9 pg", pg, 1);
    hot = 0; step(6);
    check("R9 reinrush sw", sw, 1); check("R9 reinrush pg", pg, 1);
    step(HOLD - 8);
    check("R9 full hold", pg, 1);
    step(14);
    check("R9 power", pg, 0);
    // R7 clear by reset threshold
    level(L_ZERO); step(DEG + 10);
    level(L_MID); step(6);
    power_up();
    check("R7 cleared", ev2, 0);
    // R8 wall adapter
    wall = 1; cls = 1; step(6);
    check("R8 sw", sw, 0); check("R8 ev2", ev2, 1); check("R8 cls", clsen, 0);
    wall = 0; cls = 0; step(6);
    check("R8 not latched", ev2, 0); check("R8 resume", sw, 1);
    level(L_DET); wall = 1; step(DEG + 10);
    check("R8 ignored below mark", ev2, 0); check("R8 sig", sig, 1);
    wall = 0;
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule